// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a bus-mapped watchdog for a processor subsystem. A 32-bit down-counter runs once software enables it. When the counter reaches zero, the block raises a timeout flag and reloads from a programmable reload value. The flag drives either the ordinary interrupt line or the non-maskable interrupt line. If software has not acknowledged the flag by the time the counter expires a second time, and escalation is enabled, the block asserts a system-reset request. That request stays high until the block is reset.

Software reaches the block through a simple register port: write enable, read enable, byte address, write data, and read data returned one cycle later. A key-based guard blocks changes to the configuration. While the guard is closed, writes to reload, control, acknowledge and debug are dropped. Writing any value other than the key closes the guard, and writing the key opens it. A debug option holds the count while an external halt input is high.

Top module: `wdog_timer`

## Requirements
- R1: After reset, reload reads 0xFFFFFFFF, control reads 0, the guard reads 0 (open), and irq_o, nmi_o and rst_req_o are low.
- R2: Register offsets: reload 0x00, count 0x04 (read-only), control 0x08 (bit0 run, bit1 escalate, bit2 NMI select), acknowledge 0x0C (bit0), raw flag 0x10, masked flag 0x14, debug 0x18 (bit0 stall), guard 0x1C. rd_data shows the register the cycle after rd_en.
- R3: Setting the run bit loads the counter from reload on that write's clock edge. The counter then falls by one per cycle. With reload L, the flag sets L+1 cycles after the enabling edge, and the interrupt output rises one cycle after the flag.
- R4: A timeout that occurs while the flag is still set, with the escalate bit on, raises rst_req_o. The request stays high until reset. With the escalate bit off, rst_req_o never rises.
- R5: A reload write while the counter runs copies the written value into the counter on the same edge.
- R6: A reload write of zero sets the flag at once, whether or not the counter runs.
- R7: Writing the guard with any value other than 0x1ACCE551 closes the guard. While it is closed, writes to reload, control, acknowledge and debug change nothing. The guard reads 1 when closed.
- R8: Writing 0x1ACCE551 to the guard opens it (reads 0), and configuration writes take effect again.
- R9: Software cannot clear the run bit. A control write with bit0 at 0 leaves run set, and control reads back the stored bits.
- R10: The raw register shows the flag in bit0. The masked register shows the flag ANDed with the run bit.
- R11: An acknowledge write with bit0 set clears the flag and reloads the counter, so no escalation follows that timeout.
- R12: With NMI select at 0 the flag drives irq_o. With NMI select at 1 it drives nmi_o instead. The two outputs are never high together.
- R13: With the stall bit set, the count holds while dbg_halt is high. With the stall bit clear, the count keeps falling while halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid the cycle after rd_en |
| dbg_halt | input | 1 | Processor halted by a debugger |
| irq_o | output | 1 | Timeout interrupt, ordinary route |
| nmi_o | output | 1 | Timeout interrupt, non-maskable route |
| rst_req_o | output | 1 | System-reset request after escalation |

## Verification
The bench sweeps reload values 1 through 6 with escalation on. For each value it measures, in cycles from the enabling write, when the interrupt rises and when the reset request rises. This separates an off-by-one in the reload or decrement path from an error in how the flag is tracked. Separate runs cover escalation off, acknowledgement before the second expiry, and the NMI route, which together show that the reset path depends on both the pending flag and the escalate bit. Guarded writes of each register kind, a zero reload with the counter stopped and running, and the stall bit with halt high and low test the configuration path against the counting path.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] A_RELOAD = 8'h00;
  localparam logic [7:0] A_COUNT  = 8'h04;
  localparam logic [7:0] A_CTRL   = 8'h08;
  localparam logic [7:0] A_ACK    = 8'h0C;
  localparam logic [7:0] A_RAW    = 8'h10;
  localparam logic [7:0] A_MASKED = 8'h14;
  localparam logic [7:0] A_DEBUG  = 8'h18;
  localparam logic [7:0] A_GUARD  = 8'h1C;

  // control word layout: bit2 nmi select, bit1 escalate, bit0 run
  typedef struct packed {
    logic nmi_sel;
    logic esc_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] KEY       = 32'h1ACCE551,
  parameter logic [31:0] LOAD_INIT = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] load_q,
  output ctrl_t             ctrl_q,
  output logic              stall_q,
  output logic              locked_q,
  output logic              load_wr,
  output logic              ack_wr,
  output logic              run_start
);
  logic accepted;

  always_comb begin
    accepted  = wr_en && !locked_q;
    load_wr   = accepted && (addr == ADDR_W'(A_RELOAD));
    ack_wr    = accepted && (addr == ADDR_W'(A_ACK)) && wr_data[0];
    run_start = accepted && (addr == ADDR_W'(A_CTRL)) && wr_data[0] && !ctrl_q.run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= DATA_W'(LOAD_INIT);
      ctrl_q   <= '0;
      stall_q  <= 1'b0;
      locked_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_GUARD)) begin
        locked_q <= (wr_data != DATA_W'(KEY));
      end else if (!locked_q) begin
        if (addr == ADDR_W'(A_RELOAD)) load_q <= wr_data;
        if (addr == ADDR_W'(A_CTRL)) begin
          ctrl_q.run     <= ctrl_q.run | wr_data[0];
          ctrl_q.esc_en  <= wr_data[1];
          ctrl_q.nmi_sel <= wr_data[2];
        end
        if (addr == ADDR_W'(A_DEBUG)) stall_q <= wr_data[0];
      end
    end
  end

  AST_GUARD_HOLDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr_en && addr == ADDR_W'(A_RELOAD)) |=> $stable(load_q)); // R7
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.run |=> ctrl_q.run); // R9
  AST_GUARD_HOLDS_CTRL: assert property (@(posedge clk) disable iff (rst)
    (locked_q && wr_en && addr == ADDR_W'(A_CTRL)) |=> $stable(ctrl_q)); // R7
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] LOAD_INIT = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              esc_en,
  input  logic              stall_en,
  input  logic              halt,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_wr,
  input  logic              ack_wr,
  input  logic              run_start,
  output logic [DATA_W-1:0] cnt_q,
  output logic              flag_q,
  output logic              esc_q
);
  logic tick, sw_touch, expire;

  always_comb begin
    tick     = run && !(stall_en && halt);
    sw_touch = run_start || (load_wr && run) || ack_wr;
    expire   = tick && !sw_touch && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= DATA_W'(LOAD_INIT);
      flag_q <= 1'b0;
      esc_q  <= 1'b0;
    end else begin
      if (run_start)           cnt_q <= load_val;
      else if (load_wr && run) cnt_q <= wr_data;
      else if (ack_wr)         cnt_q <= load_val;
      else if (tick)           cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;

      if (ack_wr)                                    flag_q <= 1'b0;
      else if (expire || (load_wr && wr_data == '0)) flag_q <= 1'b1;

      if (expire && flag_q && esc_en) esc_q <= 1'b1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stall_en && halt && !sw_touch) |=> $stable(cnt_q)); // R13
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !sw_touch && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_ESC_STICKY: assert property (@(posedge clk) disable iff (rst)
    esc_q |=> esc_q); // R4
  AST_ESC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(esc_q) |-> ($past(flag_q) && $past(esc_en))); // R4
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] KEY       = 32'h1ACCE551,
  parameter logic [31:0] LOAD_INIT = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dbg_halt,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] load_q, cnt_q;
  ctrl_t             ctrl_q;
  logic              stall_q, locked_q, load_wr, ack_wr, run_start;
  logic              flag_q, esc_q, pend;

  wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY(KEY), .LOAD_INIT(LOAD_INIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .load_q(load_q), .ctrl_q(ctrl_q), .stall_q(stall_q), .locked_q(locked_q),
    .load_wr(load_wr), .ack_wr(ack_wr), .run_start(run_start)
  );

  wdog_counter #(.DATA_W(DATA_W), .LOAD_INIT(LOAD_INIT)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .esc_en(ctrl_q.esc_en),
    .stall_en(stall_q), .halt(dbg_halt), .load_val(load_q), .wr_data(wr_data),
    .load_wr(load_wr), .ack_wr(ack_wr), .run_start(run_start),
    .cnt_q(cnt_q), .flag_q(flag_q), .esc_q(esc_q)
  );

  assign pend      = flag_q && ctrl_q.run;
  assign rst_req_o = esc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      nmi_o   <= 1'b0;
      rd_data <= '0;
    end else begin
      irq_o <= pend && !ctrl_q.nmi_sel;
      nmi_o <= pend && ctrl_q.nmi_sel;
      if (rd_en) begin
        case (addr)
          ADDR_W'(A_RELOAD): rd_data <= load_q;
          ADDR_W'(A_COUNT):  rd_data <= cnt_q;
          ADDR_W'(A_CTRL):   rd_data <= DATA_W'(ctrl_q);
          ADDR_W'(A_RAW):    rd_data <= DATA_W'(flag_q);
          ADDR_W'(A_MASKED): rd_data <= DATA_W'(pend);
          ADDR_W'(A_DEBUG):  rd_data <= DATA_W'(stall_q);
          ADDR_W'(A_GUARD):  rd_data <= DATA_W'(locked_q);
          default:           rd_data <= '0;
        endcase
      end
    end
  end

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && nmi_o)); // R12
  AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(flag_q)); // R12
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, dbg_halt = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic irq_o, nmi_o, rst_req_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  wdog_timer #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .dbg_halt(dbg_halt),
    .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; dbg_halt = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int k_irq, k_rst;
    do_reset();

    // R1 reset state
    rd(8'h00, v); chk("R1 reload", v, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R1 ctrl", v, 0);
    rd(8'h1C, v); chk("R1 guard", v, 0);
    chk("R1 outputs", {irq_o, nmi_o, rst_req_o}, 0);
    rd(8'h04, v); chk("R2 count reads initial", v, 32'hFFFF_FFFF);

    // R6 zero reload while stopped; R10 masked needs run
    wr(8'h00, 0);
    rd(8'h10, v); chk("R6 raw after zero reload", v, 1);
    rd(8'h14, v); chk("R10 masked while stopped", v, 0);

    // R7 guard closes; writes dropped
    wr(8'h1C, 32'h5);
    rd(8'h1C, v); chk("R7 guard closed", v, 1);
    wr(8'h00, 77); rd(8'h00, v); chk("R7 reload dropped", v, 0);
    wr(8'h0C, 1);  rd(8'h10, v); chk("R7 ack dropped", v, 1);
    wr(8'h18, 1);  rd(8'h18, v); chk("R7 debug dropped", v, 0);
    wr(8'h08, 1);  rd(8'h08, v); chk("R7 ctrl dropped", v, 0);
    idle(3); chk("R7 no irq while stopped", irq_o, 0);

    // R8 key reopens
    wr(8'h1C, KEY);
    rd(8'h1C, v); chk("R8 guard open", v, 0);
    wr(8'h00, 77); rd(8'h00, v); chk("R8 reload accepted", v, 77);
    wr(8'h0C, 1);  rd(8'h10, v); chk("R11 ack clears raw", v, 0);

    // R3/R4 sweep: timing of interrupt and escalation
    for (int L = 1; L <= 6; L++) begin
      do_reset();
      wr(8'h00, L);
      wr(8'h08, 3);
      k_irq = 0; k_rst = 0;
      for (int k = 1; k <= 3 * L + 6; k++) begin
        @(negedge clk);
        if (irq_o && k_irq == 0) k_irq = k;
        if (rst_req_o && k_rst == 0) k_rst = k;
      end
      chk("R3 irq delay", k_irq, L + 2);
      chk("R4 escalation delay", k_rst, 2 * L + 2);
      chk("R4 request held", rst_req_o, 1);
    end
    rd(8'h14, v); chk("R10 masked while running", v, 1);

    // R4 escalate off
    do_reset();
    wr(8'h00, 2); wr(8'h08, 1); idle(20);
    chk("R4 no request without escalate", rst_req_o, 0);
    chk("R12 irq route", {irq_o, nmi_o}, 2'b10);

    // R9 run bit sticky
    wr(8'h08, 32'h0);
    rd(8'h08, v); chk("R9 run stays set", v, 1);

    // R11 ack before second expiry
    do_reset();
    wr(8'h00, 10); wr(8'h08, 3); idle(12);
    chk("R11 irq before ack", irq_o, 1);
    wr(8'h0C, 1);
    rd(8'h10, v); chk("R11 raw cleared", v, 0);
    idle(14);
    chk("R11 no escalation after ack", rst_req_o, 0);
    chk("R11 flag returns on next expiry", irq_o, 1);

    // R12 NMI route
    do_reset();
    wr(8'h00, 3); wr(8'h08, 5); idle(8);
    chk("R12 nmi route", {irq_o, nmi_o}, 2'b01);

    // R5 reload write while running
    do_reset();
    wr(8'h00, 1000); wr(8'h08, 1); idle(4);
    wr(8'h00, 50);
    rd(8'h04, v); chk("R5 count copied", v, 50);

    // R6 zero reload while running
    wr(8'h00, 0);
    rd(8'h10, v); chk("R6 raw after zero while running", v, 1);

    // R13 stall
    do_reset();
    wr(8'h00, 1000); wr(8'h08, 1);
    dbg_halt = 1'b1;
    rd(8'h04, v); rd(8'h04, v2); chk("R13 counts when stall off", v - v2, 1);
    wr(8'h18, 1);
    rd(8'h04, v); idle(5); rd(8'h04, v2); chk("R13 held when halted", v2, v);
    dbg_halt = 1'b0;
    rd(8'h04, v); rd(8'h04, v2); chk("R13 resumes after halt", v - v2, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule